// File: doc/BRIEF.md
# SPI Command Shift Engine

This block is the serial engine behind one chip-select channel of an SPI master. Software writes a configuration word and a clock divider, fills a transmit FIFO, and then issues one command word. The engine pulls 32-bit words from the transmit FIFO and shifts them out on MOSI. At the same time it samples MISO and assembles 32-bit words that it pushes into a receive FIFO. It drives SCLK and chip select for the whole length of the command. The FIFOs, the register decode and the interrupt logic sit outside the block. The engine talks to the FIFOs through a show-ahead read strobe and a write strobe.

A command names an exact number of bits, taken as the count minus one, up to 28 bytes. It can enable transmit, receive or both. A continuation flag in the command keeps chip select asserted after the command ends, so the next command extends the same frame. A command that enables neither direction releases a chip select held this way.

Top module: `spi_cmd_engine`

## Requirements
- R1: Command bit 0 enables transmit and bit 1 enables receive; both set is full duplex. A command with both bits clear starts no transfer, raises neither pending nor a FIFO strobe, and deasserts a chip select held from an earlier command.
- R2: Command bits 31:16 hold the bit count minus one (63 means eight bytes); a value above 223 is treated as 223, so a command moves at most 224 bits.
- R3: The divider input is clamped to at least 4 (its 16-bit width caps it at 65535). Each bit occupies D = clamped divider system clocks, and SCLK spends the first floor(D/2) cycles of a bit in one level and the rest in the other.
- R4: Configuration bit 1 (CPOL) sets the idle SCLK level and bit 0 (CPHA) selects the mode. With CPHA=0 the first half of each bit is at the idle level; with CPHA=1 the first half is at the active level. While no transfer runs, SCLK equals the live CPOL bit.
- R5: Words are split by the bit count. Each word carries min(32, remaining) bits, so a short last word is right-justified. Configuration bit 10 clear sends each word from its top used bit down to bit 0; set sends it from bit 0 upward. MOSI holds a bit for its whole D-cycle window.
- R6: MISO is sampled floor(D/2) cycles into each bit window, or one cycle later when configuration bit 11 is set. The received bits land in the same bit positions that R5 uses for transmit. The word is pushed in the cycle after the window of its last bit.
- R7: The transmit read strobe pulses in the cycle a transmit-enabled command is accepted, and in the last cycle of each earlier word's final bit. It pulses exactly once per word.
- R8: With transmit disabled, MOSI stays 0 and the transmit FIFO is never read. With receive disabled, nothing is pushed.
- R9: A command is accepted only when ready, and ready is high exactly when no transfer is pending. Pending rises in the cycle after acceptance and stays high for N*D cycles (N bits). In the next cycle, done is high for one cycle.
- R10: Configuration bit 2 set makes chip select active low; clear makes it active high. Chip select is asserted from the cycle after acceptance and is released together with done, unless command bit 4 (continuation) was set.
- R11: After reset, pending, done, both FIFO strobes and MOSI are low, ready is high, and SCLK and chip select rest at the idle levels of the live configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Configuration: mode, chip-select polarity, order, late capture |
| div_word | input | 16 | SCLK divider in system clocks per bit |
| cmd_word | input | 32 | Command: enables, continuation, bit count minus one |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| tx_rd | output | 1 | Pop strobe for the show-ahead transmit FIFO |
| tx_rdata | input | 32 | Head word of the transmit FIFO |
| rx_wr | output | 1 | Push strobe for the receive FIFO |
| rx_wdata | output | 32 | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 1 | Chip select line |
| pending | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench counts cycles from the acceptance edge. Cycle t belongs to bit t/D at offset t mod D, which gives the due cycle of each SCLK level and MOSI bit. Done, the release of pending and the chip-select release all fall in cycle N*D, and the final receive push lands in that same cycle. The behavioural model samples every output one time unit after the falling clock edge, away from the active edge. It compares each output against the cycle the requirements name for it. Received words are rebuilt from the MISO value the bench drove in the sampling cycle of each bit. They are compared once the push strobe has been captured at the following rising edge.

// File: rtl/spi_eng_pkg.sv
// Shared definitions for the SPI command engine.
// Assumes the configuration bit positions listed in the brief.
package spi_eng_pkg;

    localparam int WORD_BITS = 32;
    localparam int DIV_FLOOR = 4;
    localparam int LEN_LSB   = 16;
    localparam int LEN_BITS  = 16;

    typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_t;

    typedef struct packed {
        logic late_cap;
        logic lsb_first;
        logic cs_low;
        logic cpol;
        logic cpha;
    } lane_cfg_t;

    // Pull the mode fields out of a configuration word.
    function automatic lane_cfg_t pick_cfg(input logic [31:0] w);
        lane_cfg_t c;
        c.cpha      = w[0];
        c.cpol      = w[1];
        c.cs_low    = w[2];
        c.lsb_first = w[10];
        c.late_cap  = w[11];
        return c;
    endfunction

endpackage

// File: rtl/spi_eng_phase.sv
// Bit-window timer: counts system clocks within one SCLK period.
// Assumes div >= 4. Produces the sampling strobe, the end-of-bit
// strobe and the SCLK half-period indicator.
module spi_eng_phase #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             late_cap,
    input  logic             cpha,
    output logic             sample,
    output logic             bit_end,
    output logic             clk_active
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] samp_pt;

    assign half       = div >> 1;
    assign samp_pt    = half + DIV_W'(late_cap);
    assign bit_end    = run && (cnt == div - 1'b1);
    assign sample     = run && (cnt == samp_pt);
    assign clk_active = cpha ? (cnt < half) : (cnt >= half);

    // Window counter: advances while running, restarts at each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (run && !bit_end)  cnt <= cnt + 1'b1;
        else                       cnt <= '0;
    end
endmodule

// File: rtl/spi_eng_shifter.sv
// Word splitter and bit shifter for both directions.
// Loads a transmit word on 'start' or on a word boundary, walks one bit
// index through it, and writes sampled bits into the same index of the
// receive word. Assumes step and sample come from the phase timer.
module spi_eng_shifter #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic              sample,
    input  logic              lsb_first,
    input  logic              miso,
    input  logic [CNT_W-1:0]  total_m1,
    input  logic [WORD_W-1:0] tx_word,
    output logic              last_bit,
    output logic              word_end,
    output logic              mosi_bit,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [CNT_W-1:0]  left;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  wleft;
    logic [WORD_W-1:0] txw;
    logic [WORD_W-1:0] rxw;
    logic [WORD_W-1:0] rxw_n;
    logic [CNT_W:0]    avail;
    logic [IDX_W:0]    nbits;
    logic              load;

    assign last_bit = (left == '0);
    assign word_end = (wleft == '0);
    assign load     = start || (step && !last_bit && word_end);
    assign avail    = start ? ({1'b0, total_m1} + 1'b1) : {1'b0, left};
    assign nbits    = (avail >= (CNT_W+1)'(WORD_W)) ? (IDX_W+1)'(WORD_W)
                                                    : avail[IDX_W:0];
    assign mosi_bit = txw[idx];

    // Merge the current MISO sample into the receive word.
    always_comb begin
        rxw_n = rxw;
        if (sample) rxw_n[idx] = miso;
    end

    // Word and bit bookkeeping for both directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left     <= '0;
            idx      <= '0;
            wleft    <= '0;
            txw      <= '0;
            rxw      <= '0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            rx_valid <= step && word_end;
            if (step && word_end) rx_word <= rxw_n;
            if (load) begin
                left  <= start ? total_m1 : left - 1'b1;
                wleft <= IDX_W'(nbits - 1'b1);
                idx   <= lsb_first ? '0 : IDX_W'(nbits - 1'b1);
                txw   <= tx_word;
                rxw   <= '0;
            end else begin
                rxw <= (step && word_end) ? '0 : rxw_n;
                if (step) begin
                    left  <= left - 1'b1;
                    wleft <= wleft - 1'b1;
                    idx   <= lsb_first ? idx + 1'b1 : idx - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// SPI command engine for one chip-select channel.
// Accepts a command word, runs an exact-length transfer against
// show-ahead FIFO interfaces, and drives SCLK, MOSI and chip select.
// Assumes cfg_word and div_word are held steady while pending is high.
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int MAX_BYTES = 28,
    parameter int DIV_W     = 16,
    parameter int WORD_W    = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic [DIV_W-1:0]  div_word,
    input  logic [31:0]       cmd_word,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    output logic              tx_rd,
    input  logic [WORD_W-1:0] tx_rdata,
    output logic              rx_wr,
    output logic [WORD_W-1:0] rx_wdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_line,
    output logic              pending,
    output logic              done
);
    localparam int MAX_BITS = MAX_BYTES * 8;
    localparam int CNT_W    = $clog2(MAX_BITS);

    eng_state_t        state;
    lane_cfg_t         cfg_now;
    lane_cfg_t         mode_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  div_cl;
    logic [LEN_BITS-1:0] len_field;
    logic [CNT_W-1:0]  total_m1;
    logic              tx_en_q, rx_en_q, cont_q, cs_hold, done_q;
    logic              running, accept, release_cmd, step, finish;
    logic              sample, bit_end, clk_active;
    logic              last_bit, word_end, mosi_bit, rx_valid;
    logic              unused_bits;

    assign cfg_now     = pick_cfg(cfg_word);
    assign len_field   = cmd_word[LEN_LSB +: LEN_BITS];
    assign total_m1    = (len_field > LEN_BITS'(MAX_BITS - 1)) ? CNT_W'(MAX_BITS - 1)
                                                               : len_field[CNT_W-1:0];
    assign div_cl      = (div_word < DIV_W'(DIV_FLOOR)) ? DIV_W'(DIV_FLOOR) : div_word;
    assign running     = (state == ST_SHIFT);
    assign accept      = cmd_valid && !running && (cmd_word[1:0] != 2'b00);
    assign release_cmd = cmd_valid && !running && (cmd_word[1:0] == 2'b00);
    assign step        = running && bit_end;
    assign finish      = step && last_bit;
    assign unused_bits = ^{cfg_word[31:12], cfg_word[9:3], cmd_word[15:5], cmd_word[3:2]};

    assign cmd_ready = !running;
    assign pending   = running;
    assign done      = done_q;
    assign tx_rd     = (accept && cmd_word[0]) ||
                       (step && tx_en_q && !last_bit && word_end);
    assign rx_wr     = rx_valid && rx_en_q;
    assign mosi      = running && tx_en_q && mosi_bit;
    assign sclk      = running ? (mode_q.cpol ^ clk_active) : cfg_now.cpol;
    assign cs_line   = cs_hold ? !mode_q.cs_low : cfg_now.cs_low;

    spi_eng_phase #(.DIV_W(DIV_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (running),
        .div        (div_q),
        .late_cap   (mode_q.late_cap),
        .cpha       (mode_q.cpha),
        .sample     (sample),
        .bit_end    (bit_end),
        .clk_active (clk_active)
    );

    spi_eng_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .step      (step),
        .sample    (sample),
        .lsb_first (accept ? cfg_now.lsb_first : mode_q.lsb_first),
        .miso      (miso),
        .total_m1  (total_m1),
        .tx_word   ((accept ? cmd_word[0] : tx_en_q) ? tx_rdata : '0),
        .last_bit  (last_bit),
        .word_end  (word_end),
        .mosi_bit  (mosi_bit),
        .rx_valid  (rx_valid),
        .rx_word   (rx_wdata)
    );

    // Command acceptance, transfer state and latched settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= '0;
            div_q   <= DIV_W'(DIV_FLOOR);
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
            cont_q  <= 1'b0;
        end else if (accept) begin
            state   <= ST_SHIFT;
            mode_q  <= cfg_now;
            div_q   <= div_cl;
            tx_en_q <= cmd_word[0];
            rx_en_q <= cmd_word[1];
            cont_q  <= cmd_word[4];
        end else if (finish) begin
            state   <= ST_IDLE;
        end
    end

    // Chip-select hold and the end-of-transfer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_hold <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept)           cs_hold <= 1'b1;
            else if (finish)      cs_hold <= cont_q;
            else if (release_cmd) cs_hold <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
// Protocol checker for spi_cmd_engine, attached by bind.
// Observes ports only.
module spi_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cmd_word,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        tx_rd,
    input logic        rx_wr,
    input logic        mosi,
    input logic        cs_line,
    input logic        pending,
    input logic        done
);
    // R9
    start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_word[1:0] != 2'b00)) |=> pending);

    // R9
    done_after_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(pending) && !pending));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    tx_pop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd |-> ((cmd_valid && cmd_ready) || pending));

    // R6
    rx_push_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> (pending || done));

    // R8
    mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> !mosi);

    // R10
    cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && $past(pending)) |-> $stable(cs_line));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_word  (cmd_word),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .tx_rd     (tx_rd),
    .rx_wr     (rx_wr),
    .mosi      (mosi),
    .cs_line   (cs_line),
    .pending   (pending),
    .done      (done)
);

// File: tb/spi_cmd_engine_bench.sv
// Behavioural reference bench for spi_cmd_engine.
module spi_cmd_engine_bench;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [15:0] div_word = 16'd4;
    logic [31:0] cmd_word = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        tx_rd;
    logic [31:0] tx_rdata = '0;
    logic        rx_wr;
    logic [31:0] rx_wdata;
    logic        sclk, mosi, cs_line, pending, done;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int pops = 0;
    logic        pop_due = 1'b0;
    logic        cs_held = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [31:0] src[$];

    always #(CLK_NS/2) clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .div_word(div_word),
        .cmd_word(cmd_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .tx_rd(tx_rd), .tx_rdata(tx_rdata), .rx_wr(rx_wr), .rx_wdata(rx_wdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_line(cs_line),
        .pending(pending), .done(done)
    );

    // FIFO models: strobes captured at the rising edge.
    always @(posedge clk) begin
        if (tx_rd) begin pops++; pop_due = 1'b1; end
        if (rx_wr) rxq.push_back(rx_wdata);
    end

    // Show-ahead head word refreshed mid-cycle.
    always @(negedge clk) begin
        if (pop_due) begin
            if (txq.size() > 0) void'(txq.pop_front());
            pop_due = 1'b0;
        end
        tx_rdata = (txq.size() > 0) ? txq[0] : 32'h0;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic run_xfer(input logic [31:0] cfg, input logic [15:0] dv,
                            input logic [31:0] cmd, input string tag);
        int d, h, samp, nb, nw, r, n, k, c, base;
        logic txe, rxe, cont, cpol, cpha, lsb, csl, act_lvl;
        logic [31:0] val;
        bit sb[$];
        logic mh[$];
        logic [31:0] exp_rx[$];
        d    = (dv < 16'd4) ? 4 : int'(dv);
        h    = d / 2;
        samp = h + int'(cfg[11]);
        txe = cmd[0]; rxe = cmd[1]; cont = cmd[4];
        cpha = cfg[0]; cpol = cfg[1]; csl = cfg[2]; lsb = cfg[10];
        act_lvl = !csl;
        nb = (cmd[31:16] > 16'd223) ? 224 : int'(cmd[31:16]) + 1;
        r = nb; nw = 0;
        while (r > 0) begin
            n = (r > 32) ? 32 : r;
            val = (nw < src.size()) ? src[nw] : 32'h0;
            for (int j = 0; j < n; j++) sb.push_back(lsb ? val[j] : val[n-1-j]);
            r -= n; nw++;
        end
        @(negedge clk);
        cfg_word = cfg; div_word = dv;
        txq.delete();
        if (txe) for (int i = 0; i < nw; i++) txq.push_back(src[i]);
        @(negedge clk);
        pops = 0; rxq.delete();
        cmd_word = cmd; cmd_valid = 1'b1;
        #1;
        chk({tag, " R9 ready"}, 32'(cmd_ready), 32'(1));
        chk({tag, " R7 pop at accept"}, 32'(tx_rd), 32'(txe));
        chk({tag, " R10 cs before"}, 32'(cs_line), 32'(cs_held ? act_lvl : csl));
        for (int t = 0; t <= nb * d; t++) begin
            if (t > 0) @(negedge clk);
            if (t == 0) begin @(negedge clk); cmd_valid = 1'b0; end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            miso = lfsr[0];
            mh.push_back(lfsr[0]);
            #1;
            if (t < nb * d) begin
                k = t / d; c = t % d;
                chk({tag, " R3 R4 sclk"}, 32'(sclk), 32'(cpol ^ (cpha ? (c < h) : (c >= h))));
                chk({tag, " R5 R8 mosi"}, 32'(mosi), 32'(txe ? sb[k] : 1'b0));
                chk({tag, " R10 cs active"}, 32'(cs_line), 32'(act_lvl));
                chk({tag, " R9 pending"}, 32'(pending), 32'(1));
                chk({tag, " R9 no done"}, 32'(done), 32'(0));
            end else begin
                chk({tag, " R9 pending low"}, 32'(pending), 32'(0));
                chk({tag, " R9 done"}, 32'(done), 32'(1));
                chk({tag, " R9 ready back"}, 32'(cmd_ready), 32'(1));
                chk({tag, " R4 idle sclk"}, 32'(sclk), 32'(cpol));
                chk({tag, " R10 cs end"}, 32'(cs_line), 32'(cont ? act_lvl : csl));
            end
        end
        @(posedge clk); #1;
        if (rxe) begin
            r = nb; base = 0;
            while (r > 0) begin
                n = (r > 32) ? 32 : r;
                val = '0;
                for (int j = 0; j < n; j++) val[lsb ? j : n-1-j] = mh[(base + j) * d + samp];
                exp_rx.push_back(val);
                base += n; r -= n;
            end
        end
        chk({tag, " R6 R8 push count"}, 32'(rxq.size()), 32'(exp_rx.size()));
        for (int i = 0; i < exp_rx.size() && i < rxq.size(); i++)
            chk({tag, " R6 rx word"}, rxq[i], exp_rx[i]);
        chk({tag, " R7 R8 pop count"}, 32'(pops), 32'(txe ? nw : 0));
        cs_held = cont;
    endtask

    task automatic release_cs(input logic [31:0] cfg);
        @(negedge clk);
        cfg_word = cfg; cmd_word = 32'h0007_0010; cmd_valid = 1'b1;
        #1;
        chk("R1 idle cmd no pop", 32'(tx_rd), 32'(0));
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R1 idle cmd no pending", 32'(pending), 32'(0));
        chk("R1 idle cmd releases cs", 32'(cs_line), 32'(cfg[2]));
        chk("R1 idle cmd sclk idle", 32'(sclk), 32'(cfg[1]));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 idle cmd no done", 32'(done), 32'(0));
        chk("R1 idle cmd still idle", 32'(pending), 32'(0));
        cs_held = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11 pending", 32'(pending), 32'(0));
        chk("R11 done", 32'(done), 32'(0));
        chk("R11 ready", 32'(cmd_ready), 32'(1));
        chk("R11 strobes", 32'({tx_rd, rx_wr}), 32'(0));
        chk("R11 mosi", 32'(mosi), 32'(0));
        chk("R11 sclk cs", 32'({sclk, cs_line}), 32'(0));

        src = '{32'h0000_A5C3};
        run_xfer(32'h0000_0000, 16'd4, 32'h000F_0003, "mode0 msb 16b");
        src = '{32'hDEAD_BEEF, 32'h0000_0096};
        run_xfer(32'h0000_0407, 16'd6, 32'h0027_0003, "mode3 lsb 40b");
        src = '{32'h1234_5678};
        run_xfer(32'h0000_0801, 16'd2, 32'h001F_0003, "R3 clamp div late capture");
        src = '{32'h00C0_FFEE};
        run_xfer(32'h0000_0002, 16'd5, 32'h0017_0001, "R1 tx only");
        src = '{};
        run_xfer(32'h0000_0004, 16'd7, 32'h002F_0002, "R1 rx only");
        src = '{32'h0000_005A};
        run_xfer(32'h0000_0004, 16'd4, 32'h0007_0013, "R10 cont first");
        src = '{32'h0000_00E1};
        run_xfer(32'h0000_0004, 16'd4, 32'h0007_0013, "R10 cont second");
        release_cs(32'h0000_0004);
        src = '{32'h0102_0304, 32'h0506_0708, 32'h090A_0B0C, 32'h0D0E_0F10,
                32'h1112_1314, 32'h1516_1718, 32'h191A_1B1C};
        run_xfer(32'h0000_0000, 16'd4, 32'h00FF_0003, "R2 length clamp");
        release_cs(32'h0000_0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule